// File: doc/BRIEF.md
# Serial Bus Controller Interrupt and Reset Hub

This block collects event strobes from a serial bus controller core and presents them to software as a register set. Each event input latches into its own sticky status bit. Software clears a status bit by writing a one to it. An enable register selects which latched events are pending. One interrupt line leaves the block. It is raised only while a single global enable bit is set and at least one pending bit is present.

The same register port carries a reset register guarded by a key. Writing the key value (0xA) produces a one-cycle reset pulse toward the controller core. The pulse also returns the block's own enable, global enable and status registers to zero. A write of any other value to the reset register is dropped without effect.

Event index `i` always lands in status bit `i`. The event kinds, by input index, are:
- 0: arbitration lost
- 1: transmit error or transfer complete
- 2: transmit FIFO empty
- 3: receive FIFO at threshold
- 4: bus idle
- 5: addressed as slave
- 6: no longer addressed as slave
- 7: transmit FIFO half empty

The bus-protocol engine that raises these events lies outside this block.

Top module: `irqc_hub`

## Requirements
- R1: Register offsets are fixed. The status register is at 0x20 and the enable register at 0x28, each read back in bits 7:0 with zeros above. The global enable register is at 0x1C and the reset register at 0x40.
- R2: The global enable is held in bit 31 of its register. A read of 0x1C returns only that bit, and all other bits read as zero whatever was written to them.
- R3: A read of any offset other than 0x1C, 0x20 or 0x28 returns zero, and this includes the reset register at 0x40.
- R4: When `evt_in[i]` is high at a clock edge, status bit `i` reads as one after that edge. The bit then stays set until it is cleared.
- R5: Writing to 0x20 clears every status bit whose write-data bit is one. Status bits written with zero keep their value.
- R6: If a clear and an event hit the same status bit at the same edge, the bit ends set.
- R7: `irq_out` is high exactly when the global enable bit is one and the bitwise AND of status and enable is nonzero.
- R8: Writing exactly 0xA to offset 0x40 drives `core_rst_out` high for the single cycle after the write edge.
- R9: A write to 0x40 with any value other than 0xA produces no reset pulse and leaves every register unchanged.
- R10: A keyed reset returns the enable, global enable and status registers to zero, so that all three read as zero afterwards.
- R11: After the hardware reset `rst_n`, all registers read zero and `irq_out` and `core_rst_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_in | input | 8 | Event strobes from the controller core |
| irq_out | output | 1 | Interrupt request |
| core_rst_out | output | 1 | One-cycle reset pulse to the controller core |

## Verification
The following rules are checked on every cycle, whatever traffic is driven:
- every event sets its status bit, and set beats clear;
- write-one clearing removes the targeted bits;
- the interrupt never rises without the global enable and a pending bit;
- a reset pulse follows only a keyed write and leaves every register at zero;
- a wrong key never produces a pulse.

The bench scenarios cover what those rules cannot show on their own. They check the exact read-back values at every offset, including the zeroing of unmapped offsets and of the global enable's unused bits. They also show that a rejected key leaves the register contents intact. Finally, they sweep every status pattern against several enable masks, with the global enable both on and off, to confirm the interrupt level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register offsets (byte addresses) seen by software
  localparam int unsigned OFF_GIE  = 32'h1C;
  localparam int unsigned OFF_STAT = 32'h20;
  localparam int unsigned OFF_IER  = 32'h28;
  localparam int unsigned OFF_RST  = 32'h40;

  // Value that must be written to the reset register to fire a core reset
  localparam int unsigned RST_KEY  = 32'hA;

  localparam int unsigned EVT_N    = 8;

  typedef logic [EVT_N-1:0] evt_vec_t;

  // Pending events: latched and enabled
  function automatic evt_vec_t pending_of(input evt_vec_t stat, input evt_vec_t ena);
    return stat & ena;
  endfunction

  // Line level: global gate and any pending
  function automatic logic line_of(input logic gate, input evt_vec_t pend);
    return gate & (|pend);
  endfunction

  // Status update: clear requested bits, then OR in new events (set wins)
  function automatic evt_vec_t status_next(input evt_vec_t stat, input evt_vec_t evt,
                                           input evt_vec_t clr);
    return (stat & ~clr) | evt;
  endfunction

endpackage

// File: rtl/irqc_status_bank.sv
module irqc_status_bank
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     soft_clr,
  input  evt_vec_t evt,
  input  logic     clr_we,
  input  evt_vec_t clr_mask,
  output evt_vec_t status
);

  evt_vec_t clr_eff;
  evt_vec_t status_d;

  assign clr_eff  = clr_we ? clr_mask : '0;
  assign status_d = soft_clr ? '0 : status_next(status, evt, clr_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  // R4: every event seen at an edge is latched afterwards
  a_r4_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr) |=> ((status & $past(evt)) == $past(evt)));

  // R5: bits written with one and not re-raised are gone
  a_r5_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !soft_clr) |=> ((status & $past(clr_mask & ~evt)) == '0));

  // R5: bits not cleared keep their value
  a_r5_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_clr) |=> (($past(status & ~clr_eff) & ~status) == '0));

  // R6: a colliding clear loses against its event
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && |(clr_mask & evt) && !soft_clr) |=>
      ((status & $past(clr_mask & evt)) == $past(clr_mask & evt)));

endmodule

// File: rtl/irqc_irq_gate.sv
module irqc_irq_gate
  import irqc_pkg::*;
(
  input  evt_vec_t status,
  input  evt_vec_t enable,
  input  logic     gie,
  output evt_vec_t pending,
  output logic     irq
);

  assign pending = pending_of(status, enable);
  assign irq     = line_of(gie, pending);

endmodule

// File: rtl/irqc_reset_key.sv
module irqc_reset_key #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned KEY    = 32'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [DATA_W-1:0] key_data,
  output logic              key_hit,
  output logic              core_rst
);

  localparam logic [DATA_W-1:0] KEY_V = DATA_W'(KEY);

  assign key_hit = key_we && (key_data == KEY_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_rst <= 1'b0;
    else        core_rst <= key_hit;
  end

  // R8: a pulse is always the result of a keyed write one cycle earlier
  a_r8_pulse_from_key: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> $past(key_we && (key_data == KEY_V)));

  // R9: a wrong value never fires the pulse
  a_r9_wrong_key_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && (key_data != KEY_V)) |=> !core_rst);

endmodule

// File: rtl/irqc_hub.sv
module irqc_hub
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_N-1:0]  evt_in,
  output logic              irq_out,
  output logic              core_rst_out
);

  localparam int unsigned GIE_BIT = DATA_W - 1;

  logic     sel_gie, sel_stat, sel_ier, sel_rst;
  logic     key_hit;
  logic     gie;
  evt_vec_t ier;
  evt_vec_t status;
  evt_vec_t pending;

  assign sel_gie  = (reg_addr == ADDR_W'(OFF_GIE));
  assign sel_stat = (reg_addr == ADDR_W'(OFF_STAT));
  assign sel_ier  = (reg_addr == ADDR_W'(OFF_IER));
  assign sel_rst  = (reg_addr == ADDR_W'(OFF_RST));

  irqc_reset_key #(.DATA_W(DATA_W), .KEY(RST_KEY)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (reg_we && sel_rst),
    .key_data (reg_wdata),
    .key_hit  (key_hit),
    .core_rst (core_rst_out)
  );

  irqc_status_bank u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (key_hit),
    .evt      (evt_in),
    .clr_we   (reg_we && sel_stat),
    .clr_mask (reg_wdata[EVT_N-1:0]),
    .status   (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= 1'b0;
      ier <= '0;
    end else if (key_hit) begin
      gie <= 1'b0;
      ier <= '0;
    end else if (reg_we) begin
      if (sel_gie) gie <= reg_wdata[GIE_BIT];
      if (sel_ier) ier <= reg_wdata[EVT_N-1:0];
    end
  end

  irqc_irq_gate u_gate (
    .status  (status),
    .enable  (ier),
    .gie     (gie),
    .pending (pending),
    .irq     (irq_out)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_gie)       reg_rdata[GIE_BIT]   = gie;
    else if (sel_stat) reg_rdata[EVT_N-1:0] = status;
    else if (sel_ier)  reg_rdata[EVT_N-1:0] = ier;
  end

  // R7: the line needs the global gate
  a_r7_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> gie);

  // R7: the line needs a latched and enabled event
  a_r7_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((status & ier) != '0));

  // R10: during the pulse every register is back at zero
  a_r10_regs_zero: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_out |-> (!gie && (ier == '0) && (status == '0)));

endmodule

// File: tb/irqc_hub_test.sv
module irqc_hub_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_in = '0;
  logic        irq_out;
  logic        core_rst_out;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irqc_hub uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_we       (reg_we),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .evt_in       (evt_in),
    .irq_out      (irq_out),
    .core_rst_out (core_rst_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    logic [31:0] d;
    logic [7:0]  emask [5];
    repeat (3) @(negedge clk);

    // R11: reset state
    rd(8'h1C, d); chk("R11 gie after reset", d, 32'h0);
    rd(8'h20, d); chk("R11 status after reset", d, 32'h0);
    rd(8'h28, d); chk("R11 enable after reset", d, 32'h0);
    chk("R11 irq after reset", {31'b0, irq_out}, 32'h0);
    chk("R11 pulse after reset", {31'b0, core_rst_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: only bit 31 of the global enable reads back
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, d); chk("R2 gie readback", d, 32'h8000_0000);
    wr(8'h1C, 32'h7FFF_FFFF);
    rd(8'h1C, d); chk("R2 gie low bits ignored", d, 32'h0);

    // R1: enable register read-back with zeroed upper bits
    wr(8'h28, 32'hFFFF_FF5A);
    rd(8'h28, d); chk("R1 enable readback", d, 32'h5A);

    // R4 / R5 / R6: per-bit set, clear, keep and collision
    for (int i = 0; i < 8; i++) begin
      logic [7:0] b;
      b = 8'(1 << i);
      wr(8'h20, 32'hFF);
      pulse_evt(b);
      rd(8'h20, d); chk($sformatf("R4 event %0d latches", i), d, {24'b0, b});
      wr(8'h20, {24'b0, ~b});
      rd(8'h20, d); chk($sformatf("R5 zero-write keeps %0d", i), d, {24'b0, b});
      wr(8'h20, {24'b0, b});
      rd(8'h20, d); chk($sformatf("R5 one-write clears %0d", i), d, 32'h0);
      @(negedge clk);
      reg_addr = 8'h20; reg_wdata = {24'b0, b}; reg_we = 1'b1; evt_in = b;
      @(negedge clk);
      reg_we = 1'b0; evt_in = '0;
      rd(8'h20, d); chk($sformatf("R6 set wins bit %0d", i), d, {24'b0, b});
    end

    // R3: unmapped offsets read zero (registers hold nonzero values)
    wr(8'h1C, 32'h8000_0000);
    pulse_evt(8'hC3);
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h1C && a != 8'h20 && a != 8'h28) begin
        rd(8'(a), d); chk($sformatf("R3 offset %02h reads zero", a), d, 32'h0);
      end
    end

    // R7: sweep every status pattern against enable masks and gate states
    emask[0] = 8'h00; emask[1] = 8'hFF; emask[2] = 8'h55;
    emask[3] = 8'hAA; emask[4] = 8'h81;
    for (int s = 0; s < 256; s++) begin
      wr(8'h20, 32'hFF);
      pulse_evt(8'(s));
      rd(8'h20, d); chk("R1 status readback", d, 32'(s));
      for (int k = 0; k < 5; k++) begin
        wr(8'h28, {24'b0, emask[k]});
        for (int g = 0; g < 2; g++) begin
          logic expi;
          wr(8'h1C, g[0] ? 32'h8000_0000 : 32'h0);
          expi = g[0] && ((8'(s) & emask[k]) != 8'h0);
          chk($sformatf("R7 irq s=%02h e=%02h g=%0d", s, emask[k], g),
              {31'b0, irq_out}, {31'b0, expi});
        end
      end
    end

    // R9: wrong keys are dropped
    wr(8'h28, 32'h3C);
    wr(8'h1C, 32'h8000_0000);
    wr(8'h20, 32'hFF);
    pulse_evt(8'h0F);
    begin
      logic [31:0] bad [4];
      bad[0] = 32'h0; bad[1] = 32'hB; bad[2] = 32'h1A; bad[3] = 32'h8000_000A;
      for (int j = 0; j < 4; j++) begin
        wr(8'h40, bad[j]);
        chk($sformatf("R9 no pulse for %h", bad[j]), {31'b0, core_rst_out}, 32'h0);
        rd(8'h28, d); chk("R9 enable kept", d, 32'h3C);
        rd(8'h1C, d); chk("R9 gie kept", d, 32'h8000_0000);
        rd(8'h20, d); chk("R9 status kept", d, 32'h0F);
      end
    end
    chk("R7 irq with pending before key", {31'b0, irq_out}, 32'h1);

    // R8 / R10: keyed reset
    wr(8'h40, 32'hA);
    chk("R8 pulse high after key", {31'b0, core_rst_out}, 32'h1);
    rd(8'h40, d); chk("R3 reset register reads zero", d, 32'h0);
    rd(8'h28, d); chk("R10 enable cleared", d, 32'h0);
    rd(8'h1C, d); chk("R10 gie cleared", d, 32'h0);
    rd(8'h20, d); chk("R10 status cleared", d, 32'h0);
    chk("R10 irq low after key", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R8 pulse lasts one cycle", {31'b0, core_rst_out}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule